// File: doc/BRIEF.md
# Sector Scan Comparison Engine

This block decides whether the sectors of a cylinder match a pattern the host supplies. The disk side presents one sector at a time, framed by a begin strobe that carries the sector's record number and its deleted-data mark, and by an end strobe. Inside that frame, the disk byte and the host byte arrive together under one valid strobe. The engine compares each pair under the chosen condition. It keeps one running verdict for the sector and a second verdict for exact equality.

A scan starts at a given record number and advances by one or by two records after each sector that does not satisfy the condition. It stops at the first sector that satisfies the condition. It also stops once the next target would pass the end-of-track record. At the end it raises a one-cycle done pulse. It then holds a hit flag, a not-satisfied flag, a control-mark flag and the record number of the last sector it handled.

Top module: `sector_scan`

## Requirements
- R1: A start pulse while idle latches the mode, step, skip, first and end records, clears the hit, not-satisfied and control-mark flags, and raises busy on the next cycle. A start pulse while busy has no effect on the scan under way or on its results.
- R2: Mode 0 (and mode 3) is the equality scan: a sector satisfies it only when every byte pair in it is equal.
- R3: Mode 1 is the disk-greater-or-equal scan and mode 2 the disk-lower-or-equal scan. Both compare unsigned, and every byte pair in the sector must pass.
- R4: A host byte of all ones is a wildcard that passes both the chosen condition and the equality test.
- R5: Only a sector whose record number equals the current target is handled. Other sectors and their bytes are ignored. After an unsatisfied sector, the target advances by 2 when step_two is 1 and by 1 otherwise.
- R6: The scan ends at the end strobe of the first handled sector that satisfies the condition. At that point scan_nsat is 0, and scan_hit is 1 exactly when every byte pair of that sector was also equal.
- R7: If a handled sector does not satisfy the condition and its record plus the step exceeds end_rec, the scan ends with scan_nsat at 1 and scan_hit at 0.
- R8: A handled sector with the deleted mark sets ctrl_mark. When skip_del is 1, such a sector counts as unsatisfied without being compared. When skip_del is 0, it is compared normally.
- R9: result_rec holds the record number of the last handled sector. The flags and result_rec stay unchanged while the engine is idle.
- R10: A byte whose valid strobe coincides with the sector end strobe is included in that sector's verdict.
- R11: done is a single-cycle pulse, raised on the same clock edge at which busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a scan with the parameters below |
| mode | input | 2 | 0 equal, 1 disk>=host, 2 disk<=host, 3 equal |
| step_two | input | 1 | 1: advance by two records, 0: by one |
| skip_del | input | 1 | Skip sectors carrying the deleted mark |
| first_rec | input | RW | Record number of the first target |
| end_rec | input | RW | End-of-track record number |
| sec_begin | input | 1 | Start of a sector frame |
| sec_rec | input | RW | Record number of the sector, valid with sec_begin |
| sec_deleted | input | 1 | Deleted-data mark of the sector, valid with sec_begin |
| byte_vld | input | 1 | A disk/host byte pair is present |
| disk_byte | input | DW | Byte read from the sector |
| host_byte | input | DW | Byte supplied by the host |
| sec_end | input | 1 | End of the sector frame |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse when the scan ends |
| scan_hit | output | 1 | Scan ended on an all-equal sector |
| scan_nsat | output | 1 | Scan ended with no sector meeting the condition |
| ctrl_mark | output | 1 | A handled sector carried the deleted mark |
| result_rec | output | RW | Record number of the last handled sector |

## Verification
The last byte of a sector and the sector end strobe can fall in the same cycle. The verdict must then fold that byte in before it decides whether the scan ends. The bench closes about half of all sectors this way and the rest with a separate end cycle. Its expected hit and not-satisfied flags include the final byte, so a design that drops the coinciding byte will report at least one wrong flag. A start pulse that arrives in the middle of a busy scan is also injected, and the final results must match the undisturbed scan.

// File: rtl/sector_scan.sv
module sector_scan #(
  parameter int DW = 8,
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode,
  input  logic          step_two,
  input  logic          skip_del,
  input  logic [RW-1:0] first_rec,
  input  logic [RW-1:0] end_rec,
  input  logic          sec_begin,
  input  logic [RW-1:0] sec_rec,
  input  logic          sec_deleted,
  input  logic          byte_vld,
  input  logic [DW-1:0] disk_byte,
  input  logic [DW-1:0] host_byte,
  input  logic          sec_end,
  output logic          busy,
  output logic          done,
  output logic          scan_hit,
  output logic          scan_nsat,
  output logic          ctrl_mark,
  output logic [RW-1:0] result_rec
);
  localparam logic [1:0] M_GE = 2'd1;
  localparam logic [1:0] M_LE = 2'd2;

  logic [1:0]    mode_r;
  logic          step_r, skip_r, sel, drop, ok_acc, eq_acc;
  logic [RW-1:0] tgt, eot_r;

  wire          wild   = &host_byte;
  wire          b_eq   = wild | (disk_byte == host_byte);
  wire          b_cond = (mode_r == M_GE) ? (disk_byte >= host_byte) :
                         (mode_r == M_LE) ? (disk_byte <= host_byte) :
                                            (disk_byte == host_byte);
  wire          b_ok   = wild | b_cond;
  wire          take   = byte_vld & sel;
  wire          sec_ok = ok_acc & (~take | b_ok) & ~drop;
  wire          sec_eq = eq_acc & (~take | b_eq);
  wire [RW:0]   nxt    = {1'b0, tgt} + (step_r ? (RW+1)'(2) : (RW+1)'(1));
  wire          closing = sel & sec_end;
  wire          finish  = closing & (sec_ok | (nxt > {1'b0, eot_r}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      done       <= 1'b0;
      scan_hit   <= 1'b0;
      scan_nsat  <= 1'b0;
      ctrl_mark  <= 1'b0;
      result_rec <= '0;
      mode_r     <= '0;
      step_r     <= 1'b0;
      skip_r     <= 1'b0;
      tgt        <= '0;
      eot_r      <= '0;
      sel        <= 1'b0;
      drop       <= 1'b0;
      ok_acc     <= 1'b0;
      eq_acc     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy      <= 1'b1;
        mode_r    <= mode;
        step_r    <= step_two;
        skip_r    <= skip_del;
        tgt       <= first_rec;
        eot_r     <= end_rec;
        scan_hit  <= 1'b0;
        scan_nsat <= 1'b0;
        ctrl_mark <= 1'b0;
        sel       <= 1'b0;
      end else if (busy) begin
        if (sec_begin && sec_rec == tgt) begin
          sel    <= 1'b1;
          drop   <= sec_deleted & skip_r;
          ok_acc <= 1'b1;
          eq_acc <= 1'b1;
          if (sec_deleted) ctrl_mark <= 1'b1;
        end else begin
          if (take) begin
            ok_acc <= ok_acc & b_ok;
            eq_acc <= eq_acc & b_eq;
          end
          if (closing) begin
            sel        <= 1'b0;
            result_rec <= tgt;
            if (finish) begin
              busy      <= 1'b0;
              done      <= 1'b1;
              scan_hit  <= sec_ok & sec_eq;
              scan_nsat <= ~sec_ok;
            end else begin
              tgt <= nxt[RW-1:0];
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sector_scan_chk.sv
module sector_scan_chk #(
  parameter int RW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          sec_begin,
  input logic          sec_deleted,
  input logic          busy,
  input logic          done,
  input logic          scan_hit,
  input logic          scan_nsat,
  input logic          ctrl_mark,
  input logic [RW-1:0] result_rec
);
  assert_start_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !scan_hit && !scan_nsat && !ctrl_mark));

  assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_hit |-> !scan_nsat);

  assert_nsat_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_nsat) |-> done);

  assert_mark_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_mark) |-> $past(sec_begin && sec_deleted));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(scan_hit) && $stable(scan_nsat) &&
                           $stable(ctrl_mark) && $stable(result_rec)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_fall_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind sector_scan sector_scan_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sec_begin(sec_begin),
  .sec_deleted(sec_deleted), .busy(busy), .done(done), .scan_hit(scan_hit),
  .scan_nsat(scan_nsat), .ctrl_mark(ctrl_mark), .result_rec(result_rec)
);

// File: tb/sector_scan_tb.sv
`timescale 1ns/1ps
module sector_scan_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 0, step_two = 0, skip_del = 0;
  logic [1:0] mode = 0;
  logic [7:0] first_rec = 0, end_rec = 0, sec_rec = 0, disk_byte = 0, host_byte = 0;
  logic sec_begin = 0, sec_deleted = 0, byte_vld = 0, sec_end = 0;
  logic busy, done, scan_hit, scan_nsat, ctrl_mark;
  logic [7:0] result_rec;
  int total = 0, bad = 0, done_seen = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sector_scan u_dut (.*);

  always @(negedge clk) if (done) done_seen++;

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int hb(int s, int r, int i);
    if ((s + r + i) % 11 == 0) return 255;
    return ((s*13 + i*29 + r*7) % 200) + 20;
  endfunction

  function automatic int db(int s, int r, int i);
    int k = (s*7 + r*3 + i*5) % 5;
    int h = hb(s, r, i);
    if (h == 255) h = 100;
    return (k == 1) ? h + 1 : (k == 2) ? h - 1 : h;
  endfunction

  task automatic feed(int r, bit del, bit decoy, int s, int md, bit merge, bit poke,
                      output bit ok, output bit eq);
    ok = 1; eq = 1;
    sec_begin = 1; sec_rec = 8'(r); sec_deleted = del;
    @(negedge clk);
    sec_begin = 0; sec_deleted = 0;
    for (int i = 0; i < 4; i++) begin
      int h = hb(s, r, i);
      int d = decoy ? h : db(s, r, i);
      bit w = (h == 255);
      byte_vld = 1; host_byte = 8'(h); disk_byte = 8'(d);
      eq &= w || (d == h);
      ok &= w || ((md == 1) ? d >= h : (md == 2) ? d <= h : d == h);
      if (poke && i == 1) begin start = 1; mode = 2'(md ^ 1); first_rec = 8'd6; end
      if (merge && i == 3) sec_end = 1;
      @(negedge clk);
      start = 0;
    end
    byte_vld = 0;
    if (!merge) begin sec_end = 1; @(negedge clk); end
    sec_end = 0;
  endtask

  task automatic run_scan(int s, int md, int st2, int sk);
    int eot = 3 + s % 4;
    int tgt = 1, step = st2 ? 2 : 1;
    bit ended = 0, e_hit = 0, e_nsat = 0, e_cm = 0;
    int e_last;
    bit ok, eq;
    e_last = result_rec;
    done_seen = 0;
    start = 1; mode = 2'(md); step_two = st2[0]; skip_del = sk[0];
    first_rec = 8'd1; end_rec = 8'(eot);
    @(negedge clk);
    start = 0;
    chk("R1 busy after start", busy, 1);
    for (int r = 1; r <= eot && !ended; r++) begin
      bit del = ((r + s) % 4 == 3);
      if (s % 3 == 0 && r == 2) feed(200, 0, 1, s, md, 1, 0, ok, eq); // R5 decoy ignored
      // R10: half of the sectors close on their final byte
      feed(r, del, 0, s, md, ((s + r) % 2 == 0), (s == 5 && r == 1), ok, eq);
      if (r == tgt) begin
        if (del) e_cm = 1;
        if (del && sk) ok = 0;
        e_last = r;
        if (ok) begin ended = 1; e_hit = eq; end
        else if (r + step > eot) begin ended = 1; e_nsat = 1; end
        else tgt = r + step;
      end
    end
    @(negedge clk); @(negedge clk);
    chk("R11 done pulses", done_seen, 1);
    chk("R11 busy low", busy, 0);
    chk("R6 R2 R3 R4 R10 hit", scan_hit, e_hit);
    chk("R7 nsat", scan_nsat, e_nsat);
    chk("R8 ctrl mark", ctrl_mark, e_cm);
    chk("R5 R9 last record", result_rec, e_last);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset busy", busy, 0);
    chk("R11 reset done", done, 0);
    chk("R6 reset hit", scan_hit, 0);
    chk("R7 reset nsat", scan_nsat, 0);
    chk("R8 reset mark", ctrl_mark, 0);
    chk("R9 reset record", result_rec, 0);
    rst_n = 1;
    @(negedge clk);
    for (int s = 0; s < 12; s++)
      for (int md = 0; md < 4; md++)
        for (int st2 = 0; st2 < 2; st2++)
          for (int sk = 0; sk < 2; sk++)
            run_scan(s, md, st2, sk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule